// File: doc/BRIEF.md
# CAN Controller Host Register Block

This block is the processor-facing register file of a CAN controller. It decodes 32-bit, word-aligned accesses from a simple request bus. It holds the operating-mode, bit-timing and warning-limit settings that drive the protocol engine. Writes to the command location become one-cycle request strobes for the engine, and that location always reads back as zero.

Eight engine event inputs are caught in sticky flags. Software clears each flag by writing a one to its bit. Each flag is masked by its own enable bit, and the unmasked flags are combined into one interrupt line. The engine's live status, its current frame-segment code and its error classification are sampled into a status word. Its two error counters can be read through a further location.

A reset-mode bit protects the configuration. While that bit is clear, the other mode bits and the bit-timing register hold their values no matter what is written to them. The protocol engine and the message buffers sit outside this block and are seen only through its strobe and status ports.

Top module: `can_hostregs`

## Requirements
- R1: During reset, mode reads 0x01 (reset mode active), status reads 0x3C, flags, enables, bit timing and command outputs are 0, the warning limit reads 0x60 and `irq_o` is low.
- R2: Mode at offset 0x00 has these bits: bit 0 reset mode, bit 1 listen-only, bit 2 loopback, bit 3 single-filter, bit 4 sleep. Bit 0 takes every write. Bits 4:1 take the written value only if bit 0 was 1 before that write; otherwise they keep their value.
- R3: Bit timing at offset 0x14 changes only on a write made while the reset-mode bit is 1. It keeps only bits 9:0, 15:14 and 23:16, so that writing all ones reads back 0x00FFC3FF.
- R4: A write to offset 0x04 drives `cmd_o` with wdata[5:0] for exactly the one cycle after the write edge; otherwise `cmd_o` is 0. The command bits are: 0 transmit, 1 abort, 2 release receive buffer, 3 clear overrun, 4 self-receive, 5 bus-off request. Reads of 0x04 return 0.
- R5: A high bit of `evt_i` sets the matching flag at offset 0x0C from the next edge. Writing 1 to a flag bit clears it, and bits written 0 are left alone. The flag order is: 0 receive, 1 transmit done, 2 error warning, 3 overrun, 4 wake-up, 5 error passive, 6 arbitration lost, 7 bus error.
- R6: When an event and a write-1 clear reach the same flag at the same edge, the flag stays set.
- R7: The enables at offset 0x10 are read-write, with each enable at its flag's bit position. `irq_o` is high exactly when some flag and its enable are both 1.
- R8: Status at offset 0x08 shows the inputs from one edge earlier: `eng_stat_i` in bits 7:0, the segment code in 20:16, the error direction in 21 (0 means the error happened while transmitting) and the error type in 23:22. All other bits are 0.
- R9: The warning limit at offset 0x18 is read-write in bits 7:0. Offset 0x1C reads the transmit error count in bits 7:0 and the receive error count in bits 23:16.
- R10: A write with address bits 1:0 not zero, or with `bus_sel_i` low, changes nothing. A read of an offset of 0x20 or above, or of an unaligned address, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Access request |
| bus_wr_i | input | 1 | 1 for a write access |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i, combinational |
| evt_i | input | N_EVT | Engine event pulses, one per flag |
| eng_stat_i | input | 8 | Engine status bits |
| seg_code_i | input | 5 | Current frame-segment code |
| err_dir_i | input | 1 | Error direction, 0 for transmit |
| err_type_i | input | 2 | Error type code |
| tx_err_i | input | 8 | Transmit error count |
| rx_err_i | input | 8 | Receive error count |
| mode_o | output | 5 | Mode bits to the engine |
| timing_o | output | 24 | Bit-timing setting |
| warn_limit_o | output | EWL_W | Error warning limit |
| cmd_o | output | N_CMD | One-cycle command strobes |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions take for granted that the bus is quiet while reset is held, so that the first check of a command strobe after reset finds no write in flight. They also take the event inputs to be ordinary synchronous levels that are sampled at the clock edge. The stimulus keeps every input at rest during reset and changes inputs only half a cycle away from the edge. Mode writes that leave reset mode, writes made while locked, unaligned and deselected writes, and events that meet a clear at the same edge are all placed by design rather than left to chance.

// File: rtl/can_hr_pkg.sv
package can_hr_pkg;
   // register slots in address order; the index is addr[4:2]
   typedef enum logic [2:0] {
      RG_MODE  = 3'd0,
      RG_CMD   = 3'd1,
      RG_STAT  = 3'd2,
      RG_IFLAG = 3'd3,
      RG_IEN   = 3'd4,
      RG_TIM   = 3'd5,
      RG_EWL   = 3'd6,
      RG_ECNT  = 3'd7
   } reg_e;

   localparam int unsigned N_REGS   = 8;
   localparam int unsigned MODE_W   = 5;
   localparam int unsigned TIM_W    = 24;
   localparam int unsigned STAT_W   = 24;

   localparam logic [MODE_W-1:0] MODE_RST = 5'h01;
   localparam logic [TIM_W-1:0]  TIM_MASK = 24'hFF_C3FF;
   localparam logic [STAT_W-1:0] STAT_RST = 24'h00_003C;

   // mode bit positions
   localparam int unsigned MB_RESET = 0;
   localparam int unsigned MB_LISTEN = 1;
   localparam int unsigned MB_LOOP  = 2;
   localparam int unsigned MB_FILT  = 3;
   localparam int unsigned MB_SLEEP = 4;
endpackage

// File: rtl/can_hr_decode.sv
module can_hr_decode
   import can_hr_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              sel_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [N_REGS-1:0] wr_en_o,
   output logic              rd_hit_o,
   output reg_e              rd_idx_o
);
   localparam int unsigned SPAN_W = $clog2(N_REGS) + 2;

   if (ADDR_W < SPAN_W) begin : g_addr_chk
      $error("can_hr_decode: ADDR_W too small for the register span");
   end

   logic aligned;
   logic in_range;

   assign aligned  = (addr_i[1:0] == 2'b00);
   assign in_range = ((addr_i >> SPAN_W) == '0);
   assign rd_hit_o = aligned && in_range;
   assign rd_idx_o = reg_e'(addr_i[SPAN_W-1:2]);

   always_comb begin
      wr_en_o = '0;
      if (sel_i && wr_i && rd_hit_o) begin
         wr_en_o[rd_idx_o] = 1'b1;
      end
   end
endmodule

// File: rtl/can_hr_ctrl.sv
module can_hr_ctrl
   import can_hr_pkg::*;
#(
   parameter int EWL_W   = 8,
   parameter int EWL_RST = 96
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_mode_i,
   input  logic              wr_tim_i,
   input  logic              wr_ewl_i,
   input  logic [TIM_W-1:0]  wdata_i,
   output logic [MODE_W-1:0] mode_o,
   output logic [TIM_W-1:0]  tim_o,
   output logic [EWL_W-1:0]  ewl_o
);
   if (EWL_W > TIM_W) begin : g_ewl_chk
      $error("can_hr_ctrl: EWL_W wider than the write path");
   end

   logic locked_n;
   assign locked_n = mode_o[MB_RESET];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_o <= MODE_RST;
         tim_o  <= '0;
         ewl_o  <= EWL_W'(EWL_RST);
      end else begin
         if (wr_mode_i) begin
            mode_o[MB_RESET] <= wdata_i[MB_RESET];
            if (locked_n) begin
               mode_o[MB_SLEEP:MB_LISTEN] <= wdata_i[MB_SLEEP:MB_LISTEN];
            end
         end
         if (wr_tim_i && locked_n) begin
            tim_o <= wdata_i & TIM_MASK;
         end
         if (wr_ewl_i) begin
            ewl_o <= wdata_i[EWL_W-1:0];
         end
      end
   end
endmodule

// File: rtl/can_hr_cmd.sv
module can_hr_cmd #(
   parameter int N_CMD = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_cmd_i,
   input  logic [N_CMD-1:0] wdata_i,
   output logic [N_CMD-1:0] cmd_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_o <= '0;
      end else begin
         cmd_o <= wr_cmd_i ? wdata_i : '0;
      end
   end
endmodule

// File: rtl/can_hr_irq.sv
module can_hr_irq #(
   parameter int N_EVT = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_flag_i,
   input  logic             wr_ien_i,
   input  logic [N_EVT-1:0] wdata_i,
   input  logic [N_EVT-1:0] evt_i,
   output logic [N_EVT-1:0] flag_o,
   output logic [N_EVT-1:0] ien_o,
   output logic             irq_o
);
   for (genvar k = 0; k < N_EVT; k++) begin : g_flag
      logic clr;
      assign clr = wr_flag_i && wdata_i[k];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_o[k] <= 1'b0;
         end else begin
            // a new event wins over a clear at the same edge
            flag_o[k] <= evt_i[k] | (flag_o[k] & ~clr);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_o <= '0;
      end else if (wr_ien_i) begin
         ien_o <= wdata_i;
      end
   end

   assign irq_o = |(flag_o & ien_o);
endmodule

// File: rtl/can_hostregs.sv
module can_hostregs
   import can_hr_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter int N_EVT   = 8,
   parameter int N_CMD   = 6,
   parameter int EWL_W   = 8,
   parameter int EWL_RST = 96
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic [N_EVT-1:0]  evt_i,
   input  logic [7:0]        eng_stat_i,
   input  logic [4:0]        seg_code_i,
   input  logic              err_dir_i,
   input  logic [1:0]        err_type_i,
   input  logic [7:0]        tx_err_i,
   input  logic [7:0]        rx_err_i,
   output logic [MODE_W-1:0] mode_o,
   output logic [TIM_W-1:0]  timing_o,
   output logic [EWL_W-1:0]  warn_limit_o,
   output logic [N_CMD-1:0]  cmd_o,
   output logic              irq_o
);
   if (DATA_W != 32) begin : g_dw_chk
      $error("can_hostregs: DATA_W must be 32");
   end
   if (N_EVT < 1 || N_EVT > 8) begin : g_evt_chk
      $error("can_hostregs: N_EVT must be 1..8");
   end
   if (N_CMD < 1 || N_CMD > 8) begin : g_cmd_chk
      $error("can_hostregs: N_CMD must be 1..8");
   end
   if (EWL_W < 1 || EWL_W > 8) begin : g_ewl_chk
      $error("can_hostregs: EWL_W must be 1..8");
   end

   logic [N_REGS-1:0] wr_en;
   logic              rd_hit;
   reg_e              rd_idx;
   logic [N_EVT-1:0]  flag_w;
   logic [N_EVT-1:0]  ien_w;
   logic [STAT_W-1:0] stat_q;
   logic              unused_bits;

   assign unused_bits = ^{bus_wdata_i[DATA_W-1:TIM_W], wr_en[RG_STAT], wr_en[RG_ECNT]};

   can_hr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .sel_i    (bus_sel_i),
      .wr_i     (bus_wr_i),
      .addr_i   (bus_addr_i),
      .wr_en_o  (wr_en),
      .rd_hit_o (rd_hit),
      .rd_idx_o (rd_idx)
   );

   can_hr_ctrl #(.EWL_W(EWL_W), .EWL_RST(EWL_RST)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_mode_i (wr_en[RG_MODE]),
      .wr_tim_i  (wr_en[RG_TIM]),
      .wr_ewl_i  (wr_en[RG_EWL]),
      .wdata_i   (bus_wdata_i[TIM_W-1:0]),
      .mode_o    (mode_o),
      .tim_o     (timing_o),
      .ewl_o     (warn_limit_o)
   );

   can_hr_cmd #(.N_CMD(N_CMD)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_cmd_i (wr_en[RG_CMD]),
      .wdata_i  (bus_wdata_i[N_CMD-1:0]),
      .cmd_o    (cmd_o)
   );

   can_hr_irq #(.N_EVT(N_EVT)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_flag_i (wr_en[RG_IFLAG]),
      .wr_ien_i  (wr_en[RG_IEN]),
      .wdata_i   (bus_wdata_i[N_EVT-1:0]),
      .evt_i     (evt_i),
      .flag_o    (flag_w),
      .ien_o     (ien_w),
      .irq_o     (irq_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= STAT_RST;
      end else begin
         stat_q <= {err_type_i, err_dir_i, seg_code_i, 8'h00, eng_stat_i};
      end
   end

   always_comb begin
      bus_rdata_o = '0;
      if (rd_hit) begin
         case (rd_idx)
            RG_MODE:  bus_rdata_o[MODE_W-1:0] = mode_o;
            RG_CMD:   bus_rdata_o = '0;
            RG_STAT:  bus_rdata_o[STAT_W-1:0] = stat_q;
            RG_IFLAG: bus_rdata_o[N_EVT-1:0] = flag_w;
            RG_IEN:   bus_rdata_o[N_EVT-1:0] = ien_w;
            RG_TIM:   bus_rdata_o[TIM_W-1:0] = timing_o;
            RG_EWL:   bus_rdata_o[EWL_W-1:0] = warn_limit_o;
            RG_ECNT: begin
               bus_rdata_o[7:0]   = tx_err_i;
               bus_rdata_o[23:16] = rx_err_i;
            end
            default:  bus_rdata_o = '0;
         endcase
      end
   end
endmodule

// File: rtl/can_hostregs_chk.sv
module can_hostregs_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int N_EVT  = 8,
   parameter int N_CMD  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel_i,
   input logic              bus_wr_i,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic [DATA_W-1:0] bus_wdata_i,
   input logic [N_EVT-1:0]  evt_i,
   input logic [4:0]        mode_o,
   input logic [23:0]       timing_o,
   input logic [N_CMD-1:0]  cmd_o,
   input logic              irq_o,
   input logic [N_EVT-1:0]  flag_q,
   input logic [N_EVT-1:0]  ien_q
);
   logic cmd_wr;
   assign cmd_wr = bus_sel_i && bus_wr_i && (bus_addr_i == ADDR_W'(4));

   // R4
   cmd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o != '0) |-> $past(cmd_wr));

   // R4
   cmd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmd_wr) |-> (cmd_o == $past(bus_wdata_i[N_CMD-1:0])));

   // R2
   mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_o[0] |=> (mode_o[4:1] == $past(mode_o[4:1])));

   // R3
   tim_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_o[0] |=> $stable(timing_o));

   // R5
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i != '0) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

   // R7
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == '0) |-> !irq_o);
endmodule

bind can_hostregs can_hostregs_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_EVT(N_EVT), .N_CMD(N_CMD)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_sel_i   (bus_sel_i),
   .bus_wr_i    (bus_wr_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .evt_i       (evt_i),
   .mode_o      (mode_o),
   .timing_o    (timing_o),
   .cmd_o       (cmd_o),
   .irq_o       (irq_o),
   .flag_q      (flag_w),
   .ien_q       (ien_w)
);

// File: tb/can_hostregs_tb.sv
module can_hostregs_tb;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0;
   logic        wr = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [31:0] wdata = 32'h0;
   logic [31:0] rdata;
   logic [7:0]  evt = 8'h00;
   logic [7:0]  est = 8'h00;
   logic [4:0]  seg = 5'h00;
   logic        edir = 1'b0;
   logic [1:0]  etype = 2'h0;
   logic [7:0]  txe = 8'h00;
   logic [7:0]  rxe = 8'h00;
   logic [4:0]  mode;
   logic [23:0] tim;
   logic [7:0]  warn;
   logic [5:0]  cmd;
   logic        irq;

   int n_vec = 0;
   int n_fail = 0;
   bit cmp_en = 1'b0;
   bit done = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   can_hostregs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .evt_i(evt), .eng_stat_i(est), .seg_code_i(seg), .err_dir_i(edir),
      .err_type_i(etype), .tx_err_i(txe), .rx_err_i(rxe),
      .mode_o(mode), .timing_o(tim), .warn_limit_o(warn), .cmd_o(cmd),
      .irq_o(irq)
   );

   // behavioural reference model
   logic [4:0]  m_mode = 5'h01;
   logic [23:0] m_tim = 24'h0;
   logic [7:0]  m_warn = 8'h60;
   logic [7:0]  m_ien = 8'h0;
   logic [7:0]  m_flag = 8'h0;
   logic [5:0]  m_cmd = 6'h0;
   logic [31:0] m_stat = 32'h3C;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 5'h01; m_tim = 24'h0; m_warn = 8'h60; m_ien = 8'h0;
         m_flag = 8'h0; m_cmd = 6'h0; m_stat = 32'h3C;
      end else begin
         bit w;
         logic [7:0] clr;
         logic [4:0] nm;
         w = sel && wr && (addr[1:0] == 2'b00) && (addr < 8'h20);
         m_cmd = (w && addr == 8'h04) ? wdata[5:0] : 6'h0;
         if (w && addr == 8'h14 && m_mode[0]) m_tim = wdata[23:0] & 24'hFFC3FF;
         nm = m_mode;
         if (w && addr == 8'h00) begin
            nm[0] = wdata[0];
            if (m_mode[0]) nm[4:1] = wdata[4:1];
         end
         m_mode = nm;
         if (w && addr == 8'h18) m_warn = wdata[7:0];
         if (w && addr == 8'h10) m_ien = wdata[7:0];
         clr = (w && addr == 8'h0C) ? wdata[7:0] : 8'h0;
         m_flag = (m_flag & ~clr) | evt;
         m_stat = {8'h0, etype, edir, seg, 8'h0, est};
      end
   end

   function automatic logic [31:0] exp_rd(input logic [7:0] a);
      if (a[1:0] != 2'b00 || a >= 8'h20) return 32'h0;
      case (a)
         8'h00: return {27'h0, m_mode};
         8'h08: return m_stat;
         8'h0C: return {24'h0, m_flag};
         8'h10: return {24'h0, m_ien};
         8'h14: return {8'h0, m_tim};
         8'h18: return {24'h0, m_warn};
         8'h1C: return {8'h0, rxe, 8'h0, txe};
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(input logic [7:0] a);
      if (a[1:0] != 2'b00 || a >= 8'h20) return "R10";
      case (a)
         8'h00: return "R2";
         8'h04: return "R4";
         8'h08: return "R8";
         8'h0C: return "R5";
         8'h10: return "R7";
         8'h14: return "R3";
         default: return "R9";
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (cmp_en && !done) begin
         chk(mode == m_mode, "R2", {27'h0, mode}, {27'h0, m_mode});
         chk(tim == m_tim, "R3", {8'h0, tim}, {8'h0, m_tim});
         chk(warn == m_warn, "R9", {24'h0, warn}, {24'h0, m_warn});
         chk(cmd == m_cmd, "R4", {26'h0, cmd}, {26'h0, m_cmd});
         chk(irq == |(m_flag & m_ien), "R7", {31'h0, irq}, {31'h0, |(m_flag & m_ien)});
         chk(rdata == exp_rd(addr), tag_of(addr), rdata, exp_rd(addr));
      end
   end

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); #1;
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); #1;
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic read_chk(input logic [7:0] a, input logic [31:0] e, input string req);
      addr = a;
      #2;
      chk(rdata == e, req, rdata, e);
   endtask

   task automatic pulse_evt(input logic [7:0] v);
      @(negedge clk); #1; evt = v;
      @(negedge clk); #1; evt = 8'h00;
   endtask

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset values, read while reset is still held
      repeat (2) @(negedge clk);
      #1;
      read_chk(8'h00, 32'h01, "R1");
      read_chk(8'h08, 32'h3C, "R1");
      read_chk(8'h0C, 32'h00, "R1");
      read_chk(8'h10, 32'h00, "R1");
      read_chk(8'h14, 32'h00, "R1");
      read_chk(8'h18, 32'h60, "R1");
      chk(irq == 1'b0 && cmd == 6'h0, "R1", {31'h0, irq}, 32'h0);
      @(negedge clk); #1;
      rst_n = 1'b1;
      cmp_en = 1'b1;

      // R2: leave reset mode, setting listen-only and loopback together
      bus_write(8'h00, 32'h06);
      read_chk(8'h00, 32'h06, "R2");
      bus_write(8'h00, 32'h18);
      read_chk(8'h00, 32'h06, "R2");

      // R3: timing is locked outside reset mode
      bus_write(8'h14, 32'hFFFF_FFFF);
      read_chk(8'h14, 32'h0, "R3");
      bus_write(8'h00, 32'h01);
      read_chk(8'h00, 32'h07, "R2");
      bus_write(8'h14, 32'hFFFF_FFFF);
      read_chk(8'h14, 32'h00FF_C3FF, "R3");

      // R9
      bus_write(8'h18, 32'h1234);
      read_chk(8'h18, 32'h34, "R9");
      txe = 8'hA5; rxe = 8'h5A;
      read_chk(8'h1C, 32'h005A_00A5, "R9");

      // R4: one-cycle strobe, write-only location
      @(negedge clk); #1;
      sel = 1'b1; wr = 1'b1; addr = 8'h04; wdata = 32'h3F;
      @(negedge clk);
      chk(cmd == 6'h3F, "R4", {26'h0, cmd}, 32'h3F);
      #1; sel = 1'b0; wr = 1'b0;
      @(negedge clk);
      chk(cmd == 6'h00, "R4", {26'h0, cmd}, 32'h0);
      #1;
      read_chk(8'h04, 32'h0, "R4");

      // R5: sticky flags, partial clear
      pulse_evt(8'h81);
      read_chk(8'h0C, 32'h81, "R5");
      bus_write(8'h0C, 32'h01);
      read_chk(8'h0C, 32'h80, "R5");

      // R6: event meets clear at the same edge
      @(negedge clk); #1;
      evt = 8'h80; sel = 1'b1; wr = 1'b1; addr = 8'h0C; wdata = 32'h80;
      @(negedge clk); #1;
      evt = 8'h00; sel = 1'b0; wr = 1'b0;
      read_chk(8'h0C, 32'h80, "R6");
      bus_write(8'h0C, 32'h80);
      read_chk(8'h0C, 32'h00, "R6");

      // R7: masked interrupt
      bus_write(8'h10, 32'h04);
      pulse_evt(8'h02);
      chk(irq == 1'b0, "R7", {31'h0, irq}, 32'h0);
      pulse_evt(8'h04);
      chk(irq == 1'b1, "R7", {31'h0, irq}, 32'h1);
      bus_write(8'h0C, 32'h06);
      chk(irq == 1'b0, "R7", {31'h0, irq}, 32'h0);

      // R8: status fields
      @(negedge clk); #1;
      est = 8'h5A; seg = 5'h13; edir = 1'b1; etype = 2'h2;
      @(negedge clk); #1;
      read_chk(8'h08, 32'h00B3_005A, "R8");

      // R10: unaligned and deselected writes
      bus_write(8'h01, 32'h00);
      read_chk(8'h00, 32'h07, "R10");
      @(negedge clk); #1;
      sel = 1'b0; wr = 1'b1; addr = 8'h10; wdata = 32'hFF;
      @(negedge clk); #1;
      wr = 1'b0;
      read_chk(8'h10, 32'h04, "R10");
      read_chk(8'h24, 32'h0, "R10");

      // mixed traffic against the per-clock model
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk); #1;
         sel   = ($urandom % 3) != 0;
         wr    = ($urandom % 2) != 0;
         case ($urandom % 12)
            0: addr = 8'h00;  1: addr = 8'h04;  2: addr = 8'h08;
            3: addr = 8'h0C;  4: addr = 8'h10;  5: addr = 8'h14;
            6: addr = 8'h18;  7: addr = 8'h1C;  8: addr = 8'h20;
            9: addr = 8'h02;  10: addr = 8'h0D; default: addr = 8'h0C;
         endcase
         wdata = $urandom;
         evt   = 8'($urandom & $urandom & $urandom);
         est   = 8'($urandom);
         seg   = 5'($urandom);
         edir  = 1'($urandom);
         etype = 2'($urandom);
         txe   = 8'($urandom);
         rxe   = 8'($urandom);
      end
      @(negedge clk); #1;
      sel = 1'b0; wr = 1'b0; evt = 8'h00;
      repeat (3) @(negedge clk);
      #1;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule